// File: doc/BRIEF.md
# Host port slave with indirect memory window and mailboxes

This block lets an external processor reach a word-organised internal memory and exchange single words with on-chip logic over a narrow 16-bit port. A 2-bit register select picks one of four locations. Memory traffic is indirect. The host first loads a pointer register with a byte address and then reads or writes a data window. After each data access the pointer moves on by one word, so a single pointer load is enough for a burst of consecutive words.

The same port carries a word-wide mailbox in each direction. A word the host puts in the mailbox raises a pending flag toward the internal side, and stays pending until the internal side acknowledges it. A word the internal side posts raises a flag in the status location and drives the host interrupt. Reading the mailbox from the host side returns that word and clears the flag. The port also enforces a minimum spacing between host cycles. After each accepted cycle a ready output stays low for a fixed number of clocks. With the default of 6 clocks and a 48 MHz core clock, this gives the 125 ns host cycle time.

Top module: `hpi_slave`

## Requirements
- R1: After reset, hp_rdata is 0, hp_rdy is 1, hp_irq is 0, core_mbx_in_valid is 0, and both the pointer (select 2) and the status word (select 3) read as 0.
- R2: A host write to select 2 loads all 16 bits of the pointer. A host read of select 2 returns those 16 bits unchanged.
- R3: Writing select 0 stores a word at the pointer, and reading select 0 returns the stored word. Pointer bit 0 plays no part in choosing the word, so pointers 0x0010 and 0x0011 reach the same word.
- R4: Every accepted read or write of select 0 adds 2 to the pointer, modulo 2^16. A burst after one pointer load therefore reaches consecutive words, and a burst that starts at 0xFFFE continues at 0x0000. The memory holds 2^MEM_AW words, indexed by pointer bits MEM_AW down to 1.
- R5: A host write to select 1 puts the word on core_mbx_in_data and sets core_mbx_in_valid on the next cycle. A pulse on core_mbx_in_ack clears core_mbx_in_valid. If a host mailbox write and an acknowledge land in the same cycle, the flag stays set.
- R6: A pulse on core_mbx_wr posts core_mbx_wdata as the reply word, sets the reply flag and raises hp_irq on the next cycle. A host read of select 1 returns the reply word, and hp_irq is low from the following cycle on.
- R7: Reading select 3 gives bit 0 = reply pending to the host and bit 1 = host word not yet acknowledged by the internal side. All other bits read 0. Host writes to select 3 change no state.
- R8: After each accepted host cycle, hp_rdy is low for exactly CYC_MIN-1 clocks. A request made while hp_rdy is low is ignored and changes no register or memory word.
- R9: If core_mbx_wr and a host read of select 1 land in the same cycle, the host gets the older reply word, and the reply flag and hp_irq stay set for the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_req | input | 1 | Host cycle request, taken on a clock edge while hp_rdy is high |
| hp_we | input | 1 | 1 = host write, 0 = host read |
| hp_sel | input | 2 | Register select: 0 data, 1 mailbox, 2 pointer, 3 status |
| hp_wdata | input | 16 | Host write word |
| hp_rdata | output | 16 | Host read word, registered on the accepting edge |
| hp_rdy | output | 1 | High when a new host cycle may be accepted |
| hp_irq | output | 1 | Host interrupt, high while a reply word is pending |
| core_mbx_wr | input | 1 | Internal side posts a reply word |
| core_mbx_wdata | input | 16 | Reply word from the internal side |
| core_mbx_in_ack | input | 1 | Internal side has consumed the host word |
| core_mbx_in_data | output | 16 | Last word written by the host to the mailbox |
| core_mbx_in_valid | output | 1 | Host word waiting for the internal side |

## Verification
The assertions assume that hp_req, hp_we, hp_sel and the internal mailbox strobes are known and steady around each clock edge. They do not depend on the host honouring hp_rdy. The property for R8 watches a request made while hp_rdy is low and checks that the pointer does not move. The bench changes every input on the falling edge and normally waits for hp_rdy before it raises hp_req. The one exception is a deliberate early request, used to exercise the ignore rule.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_MBOX = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_STAT = 2'd3
  } hpi_sel_e;

  // pointer step after a data-window access: one 16-bit word
  function automatic logic [15:0] ptr_step(input logic [15:0] p);
    return p + 16'd2;
  endfunction

  // status word layout: bit0 reply pending, bit1 host word unacknowledged
  function automatic logic [15:0] status_word(input logic out_pend,
                                              input logic in_pend);
    return {14'd0, in_pend, out_pend};
  endfunction

endpackage

// File: rtl/hpi_pace.sv
module hpi_pace #(
  parameter int CYC_MIN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rdy,
  output logic acc
);
  localparam int CW = $clog2(CYC_MIN + 1);

  logic [CW-1:0] gap_q;

  assign rdy = (gap_q == '0);
  assign acc = req && rdy;

  always_ff @(posedge clk) begin
    if (!rst_n)             gap_q <= '0;
    else if (acc)           gap_q <= CW'(CYC_MIN - 1);
    else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
  end
endmodule

// File: rtl/hpi_window.sv
module hpi_window
  import hpi_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_wr,
  input  logic        data_wr,
  input  logic        data_rd,
  input  logic [15:0] wdata,
  output logic [15:0] ptr_q,
  output logic [15:0] rd_word
);
  localparam int WORDS = 1 << MEM_AW;

  logic [15:0]       mem [WORDS];
  logic [MEM_AW-1:0] idx;

  assign idx     = ptr_q[MEM_AW:1];
  assign rd_word = mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr_q <= '0;
    else if (ptr_wr)           ptr_q <= wdata;
    else if (data_wr || data_rd) ptr_q <= ptr_step(ptr_q);
  end

  always_ff @(posedge clk) begin
    if (data_wr) mem[idx] <= wdata;
  end
endmodule

// File: rtl/hpi_mailbox.sv
module hpi_mailbox (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  input  logic        core_wr,
  input  logic [15:0] core_wdata,
  input  logic        core_ack,
  output logic [15:0] in_word,
  output logic        in_valid,
  output logic [15:0] out_word,
  output logic        out_valid
);
  // host -> internal direction; a new word wins over a same-cycle ack
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_word  <= '0;
      in_valid <= 1'b0;
    end else if (host_wr) begin
      in_word  <= host_wdata;
      in_valid <= 1'b1;
    end else if (core_ack) begin
      in_valid <= 1'b0;
    end
  end

  // internal -> host direction; a new post wins over a same-cycle host read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else if (core_wr) begin
      out_word  <= core_wdata;
      out_valid <= 1'b1;
    end else if (host_rd) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hpi_slave.sv
module hpi_slave
  import hpi_pkg::*;
#(
  parameter int CYC_MIN = 6,
  parameter int MEM_AW  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hp_req,
  input  logic        hp_we,
  input  logic [1:0]  hp_sel,
  input  logic [15:0] hp_wdata,
  output logic [15:0] hp_rdata,
  output logic        hp_rdy,
  output logic        hp_irq,
  input  logic        core_mbx_wr,
  input  logic [15:0] core_mbx_wdata,
  input  logic        core_mbx_in_ack,
  output logic [15:0] core_mbx_in_data,
  output logic        core_mbx_in_valid
);
  hpi_sel_e    sel;
  logic        acc;
  logic        acc_rd, acc_wr;
  logic        acc_data, acc_mbx_rd, acc_mbx_wr, acc_ptr_wr;
  logic [15:0] ptr_q, mem_word, out_word;
  logic        out_valid;

  assign sel        = hpi_sel_e'(hp_sel);
  assign acc_rd     = acc && !hp_we;
  assign acc_wr     = acc &&  hp_we;
  assign acc_data   = acc && (sel == SEL_DATA);
  assign acc_mbx_rd = acc_rd && (sel == SEL_MBOX);
  assign acc_mbx_wr = acc_wr && (sel == SEL_MBOX);
  assign acc_ptr_wr = acc_wr && (sel == SEL_PTR);

  hpi_pace #(.CYC_MIN(CYC_MIN)) u_pace (
    .clk (clk), .rst_n (rst_n), .req (hp_req), .rdy (hp_rdy), .acc (acc)
  );

  hpi_window #(.MEM_AW(MEM_AW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr_wr  (acc_ptr_wr),
    .data_wr (acc_data && hp_we),
    .data_rd (acc_data && !hp_we),
    .wdata   (hp_wdata),
    .ptr_q   (ptr_q),
    .rd_word (mem_word)
  );

  hpi_mailbox u_mbx (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (acc_mbx_wr),
    .host_rd    (acc_mbx_rd),
    .host_wdata (hp_wdata),
    .core_wr    (core_mbx_wr),
    .core_wdata (core_mbx_wdata),
    .core_ack   (core_mbx_in_ack),
    .in_word    (core_mbx_in_data),
    .in_valid   (core_mbx_in_valid),
    .out_word   (out_word),
    .out_valid  (out_valid)
  );

  assign hp_irq = out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) hp_rdata <= '0;
    else if (acc_rd) begin
      unique case (sel)
        SEL_DATA: hp_rdata <= mem_word;
        SEL_MBOX: hp_rdata <= out_word;
        SEL_PTR:  hp_rdata <= ptr_q;
        SEL_STAT: hp_rdata <= status_word(out_valid, core_mbx_in_valid);
      endcase
    end
  end
endmodule

// File: rtl/hpi_slave_chk.sv
module hpi_slave_chk #(
  parameter int CYC_MIN = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hp_req,
  input logic        hp_rdy,
  input logic        hp_irq,
  input logic        acc,
  input logic        acc_data,
  input logic        acc_mbx_rd,
  input logic        acc_mbx_wr,
  input logic        core_mbx_wr,
  input logic        core_mbx_in_valid,
  input logic [15:0] ptr_q
);
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data |=> ptr_q == $past(ptr_q) + 16'd2);

  a_r8_busy_after: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && CYC_MIN > 1) |=> !hp_rdy);

  a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_req && !hp_rdy) |=> $stable(ptr_q));

  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    core_mbx_wr |=> hp_irq);

  a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mbx_rd && !core_mbx_wr) |=> !hp_irq);

  a_r5_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mbx_wr |=> core_mbx_in_valid);
endmodule

bind hpi_slave hpi_slave_chk #(.CYC_MIN(CYC_MIN)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .hp_req            (hp_req),
  .hp_rdy            (hp_rdy),
  .hp_irq            (hp_irq),
  .acc               (acc),
  .acc_data          (acc_data),
  .acc_mbx_rd        (acc_mbx_rd),
  .acc_mbx_wr        (acc_mbx_wr),
  .core_mbx_wr       (core_mbx_wr),
  .core_mbx_in_valid (core_mbx_in_valid),
  .ptr_q             (ptr_q)
);

// File: tb/sim_hpi_slave.sv
module sim_hpi_slave;
  localparam int CYC_MIN = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hp_req = 1'b0, hp_we = 1'b0;
  logic [1:0]  hp_sel = 2'd0;
  logic [15:0] hp_wdata = '0;
  logic [15:0] hp_rdata;
  logic        hp_rdy, hp_irq;
  logic        core_mbx_wr = 1'b0, core_mbx_in_ack = 1'b0;
  logic [15:0] core_mbx_wdata = '0;
  logic [15:0] core_mbx_in_data;
  logic        core_mbx_in_valid;

  int n_chk = 0, n_bad = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  hpi_slave #(.CYC_MIN(CYC_MIN), .MEM_AW(10)) u0 (.*);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // waits for ready, runs one host cycle; returns at the falling edge after acceptance
  task automatic host_op(input logic we, input logic [1:0] sel, input logic [15:0] wd,
                         output logic [15:0] rd);
    while (!hp_rdy) @(negedge clk);
    hp_req = 1'b1; hp_we = we; hp_sel = sel; hp_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    hp_req = 1'b0; hp_we = 1'b0;
    rd = hp_rdata;
  endtask

  task automatic core_post(input logic [15:0] w);
    core_mbx_wr = 1'b1; core_mbx_wdata = w;
    @(posedge clk); @(negedge clk);
    core_mbx_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", hp_rdata, 16'h0);
    check("R1 rdy", {15'd0, hp_rdy}, 16'd1);
    check("R1 irq", {15'd0, hp_irq}, 16'd0);
    check("R1 in_valid", {15'd0, core_mbx_in_valid}, 16'd0);
    host_op(1'b0, 2'd2, 16'h0, rv); check("R1 pointer", rv, 16'h0);
    host_op(1'b0, 2'd3, 16'h0, rv); check("R1 status", rv, 16'h0);
  endtask

  task automatic t_ptr();
    host_op(1'b1, 2'd2, 16'hA5C3, rv);
    host_op(1'b0, 2'd2, 16'h0, rv); check("R2 pointer readback", rv, 16'hA5C3);
  endtask

  task automatic t_word();
    host_op(1'b1, 2'd2, 16'h0010, rv);
    host_op(1'b1, 2'd0, 16'h1234, rv);
    host_op(1'b1, 2'd2, 16'h0011, rv);
    host_op(1'b0, 2'd0, 16'h0, rv); check("R3 odd pointer same word", rv, 16'h1234);
  endtask

  task automatic t_burst();
    host_op(1'b1, 2'd2, 16'h0040, rv);
    for (int i = 0; i < 4; i++) host_op(1'b1, 2'd0, 16'hB000 + 16'(i), rv);
    host_op(1'b0, 2'd2, 16'h0, rv); check("R4 pointer after burst write", rv, 16'h0048);
    host_op(1'b1, 2'd2, 16'h0040, rv);
    for (int i = 0; i < 4; i++) begin
      host_op(1'b0, 2'd0, 16'h0, rv); check("R4 burst read word", rv, 16'hB000 + 16'(i));
    end
    host_op(1'b1, 2'd2, 16'h0044, rv);
    host_op(1'b0, 2'd0, 16'h0, rv); check("R3 single read mid burst", rv, 16'hB002);
  endtask

  task automatic t_wrap();
    host_op(1'b1, 2'd2, 16'hFFFE, rv);
    host_op(1'b1, 2'd0, 16'hAAAA, rv);
    host_op(1'b1, 2'd0, 16'h5555, rv);
    host_op(1'b0, 2'd2, 16'h0, rv); check("R4 pointer wrap", rv, 16'h0002);
    host_op(1'b1, 2'd2, 16'h0000, rv);
    host_op(1'b0, 2'd0, 16'h0, rv); check("R4 word after wrap", rv, 16'h5555);
  endtask

  task automatic t_mbox_in();
    host_op(1'b1, 2'd1, 16'hC0DE, rv);
    check("R5 in_valid set", {15'd0, core_mbx_in_valid}, 16'd1);
    check("R5 in_data", core_mbx_in_data, 16'hC0DE);
    host_op(1'b0, 2'd3, 16'h0, rv); check("R7 status in pending", rv, 16'h0002);
    core_mbx_in_ack = 1'b1; @(posedge clk); @(negedge clk); core_mbx_in_ack = 1'b0;
    check("R5 ack clears", {15'd0, core_mbx_in_valid}, 16'd0);
    while (!hp_rdy) @(negedge clk);
    hp_req = 1'b1; hp_we = 1'b1; hp_sel = 2'd1; hp_wdata = 16'hBEEF;
    core_mbx_in_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    hp_req = 1'b0; hp_we = 1'b0; core_mbx_in_ack = 1'b0;
    check("R5 write beats ack", {15'd0, core_mbx_in_valid}, 16'd1);
    check("R5 new in_data", core_mbx_in_data, 16'hBEEF);
    core_mbx_in_ack = 1'b1; @(posedge clk); @(negedge clk); core_mbx_in_ack = 1'b0;
  endtask

  task automatic t_mbox_out();
    core_post(16'h0FED);
    check("R6 irq raised", {15'd0, hp_irq}, 16'd1);
    host_op(1'b0, 2'd3, 16'h0, rv); check("R7 status out pending", rv, 16'h0001);
    host_op(1'b0, 2'd1, 16'h0, rv); check("R6 reply word", rv, 16'h0FED);
    check("R6 irq dropped", {15'd0, hp_irq}, 16'd0);
    host_op(1'b1, 2'd3, 16'hFFFF, rv);
    host_op(1'b0, 2'd3, 16'h0, rv); check("R7 status write ignored", rv, 16'h0000);
    host_op(1'b0, 2'd2, 16'h0, rv); check("R7 pointer kept", rv, 16'h0002);
  endtask

  task automatic t_collide();
    core_post(16'h1111);
    while (!hp_rdy) @(negedge clk);
    hp_req = 1'b1; hp_we = 1'b0; hp_sel = 2'd1;
    core_mbx_wr = 1'b1; core_mbx_wdata = 16'h2222;
    @(posedge clk); @(negedge clk);
    hp_req = 1'b0; core_mbx_wr = 1'b0;
    check("R9 old word returned", hp_rdata, 16'h1111);
    check("R9 irq kept", {15'd0, hp_irq}, 16'd1);
    host_op(1'b0, 2'd1, 16'h0, rv); check("R9 new word", rv, 16'h2222);
    check("R9 irq cleared", {15'd0, hp_irq}, 16'd0);
  endtask

  task automatic t_pace();
    int lo;
    host_op(1'b1, 2'd2, 16'h0100, rv);
    lo = 0;
    while (!hp_rdy) begin lo++; @(negedge clk); end
    check("R8 busy clocks", 16'(lo), 16'(CYC_MIN - 1));
    host_op(1'b1, 2'd2, 16'h0200, rv);
    check("R8 rdy low after accept", {15'd0, hp_rdy}, 16'd0);
    hp_req = 1'b1; hp_we = 1'b1; hp_sel = 2'd2; hp_wdata = 16'h0300;
    @(posedge clk); @(negedge clk);
    hp_req = 1'b0; hp_we = 1'b0;
    host_op(1'b0, 2'd2, 16'h0, rv); check("R8 early request ignored", rv, 16'h0200);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr();
    t_word();
    t_burst();
    t_wrap();
    t_mbox_in();
    t_mbox_out();
    t_collide();
    t_pace();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule